// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Stage Buffer

This block receives asynchronous serial characters from a single data line. It works from a sample enable that pulses sixteen times per bit period. A 4-bit phase counter advances once per enable pulse and splits each bit into sixteen phases. The line level is captured on phases 7, 8 and 9, and the bit value is the majority of those three captures. A falling edge on the idle-high line starts a reception. The start bit is confirmed by the same vote, so a short low pulse is rejected as noise. Eight data bits follow, least significant bit first, and then one stop bit.

Each bit is shifted into a first-stage register. When the stop bit votes high, the whole character moves in one step into a holding register. The first stage is then free for the next character while software still has the previous one. In direct mode, the transfer sets a buffer-full flag and pulses a receive interrupt. When a FIFO is attached, the transfer instead pulses a push strobe, and the full flag stays clear. A read strobe releases the holding register. If a new character arrives while the flag is still set, the holding register is overwritten and an overrun flag is set.

Top module: `orx_receiver`

## Requirements
- R1: The phase counter advances only on clock cycles where `os_tick` is high. Every bit lasts 16 `os_tick` pulses, and the number of idle clock cycles between pulses has no effect on the received value.
- R2: The level of each bit is the majority of the line on pulses 7, 8 and 9 of that bit, counting the first pulse of the bit as 1. A single wrong sample among the three does not change the bit. Two wrong samples invert it.
- R3: A falling edge of `rxd` seen on an `os_tick` pulse, while the line was high on the previous pulse, starts a reception. If the vote in the middle of the start bit is 1, the receiver returns to idle and produces no character.
- R4: The frame is eight data bits, the first received bit landing in `rx_data[0]`, followed by one stop bit. A stop bit that votes 0 discards the character: no flag, strobe or data change results.
- R5: A character whose stop bit votes 1 is copied into the holding register, which drives `rx_data`. In direct mode (`fifo_mode`=0), `rx_full` becomes 1 at the same time.
- R6: In direct mode, `rx_irq` is high for exactly one clock cycle per received character, in the cycle where `rx_full` first shows the new character.
- R7: In FIFO mode (`fifo_mode`=1), each received character produces a one-cycle `fifo_push` pulse, with the character on `rx_data`. `rx_full` is 0 and `rx_irq` stays low.
- R8: A one-cycle `rd_strobe` clears `rx_full` and `overrun` on the next clock edge.
- R9: In direct mode, a character that completes while `rx_full` is 1 and no read strobe is present sets `overrun` to 1 and overwrites `rx_data`. `rx_full` stays 1.
- R10: After reset, `rx_data` is 0 and `rx_full`, `fifo_push`, `rx_irq` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial data line, idle high |
| os_tick | input | 1 | Sample enable, 16 pulses per bit |
| fifo_mode | input | 1 | 1: hand characters to a FIFO; 0: direct mode |
| rd_strobe | input | 1 | Read of the holding register |
| rx_data | output | 8 | Holding register contents |
| rx_full | output | 1 | Holding register holds an unread character |
| fifo_push | output | 1 | One-cycle strobe per character in FIFO mode |
| rx_irq | output | 1 | One-cycle receive interrupt in direct mode |
| overrun | output | 1 | A character overwrote an unread one |

## Verification
On every cycle, the assertions check that the phase counter and state hold still between sample pulses. They also check that an interrupt never appears without the full flag, that a push strobe never coincides with a set full flag, that overrun rises only while the buffer is full, and that a read releases the buffer. Only the bench scenarios can show the values that arrive. These include the sweep over every byte value with one corrupted mid-bit sample, the inversion of a bit by two corrupted samples, and the rejection of short start pulses and of a bad stop bit. The bench scenarios also show the overwrite rule and the FIFO hand-off.

// File: rtl/orx_pkg.sv
package orx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } orx_state_e;
endpackage

// File: rtl/orx_sampler.sv
module orx_sampler #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic             active,
    input  logic [CNT_W-1:0] phase,
    output logic             vote
);
    localparam int OSR = 1 << CNT_W;
    localparam logic [CNT_W-1:0] SMP_A = CNT_W'(OSR / 2 - 2);
    localparam logic [CNT_W-1:0] SMP_B = CNT_W'(OSR / 2 - 1);

    typedef struct packed {
        logic s_a;
        logic s_b;
    } smp_t;

    smp_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (os_tick && active) begin
            if (phase == SMP_A) q_d.s_a = rxd;
            if (phase == SMP_B) q_d.s_b = rxd;
        end
    end

    // R2: two stored samples plus the live third one
    assign vote = (q_q.s_a & q_q.s_b) | (q_q.s_a & rxd) | (q_q.s_b & rxd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '1;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/orx_framer.sv
module orx_framer
    import orx_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 os_tick,
    input  logic                 rxd,
    input  logic                 vote,
    output logic                 active,
    output logic [CNT_W-1:0]     phase,
    output logic                 xfer,
    output logic [DATA_BITS-1:0] xfer_data
);
    localparam int OSR   = 1 << CNT_W;
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] SMP_C    = CNT_W'(OSR / 2);
    localparam logic [CNT_W-1:0] LAST_PH  = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(DATA_BITS - 1);

    typedef struct packed {
        orx_state_e           state;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [DATA_BITS-1:0] sreg;
        logic                 prev;
    } frm_t;

    frm_t q_q, q_d;

    always_comb begin
        q_d  = q_q;
        xfer = 1'b0;
        if (os_tick) begin
            q_d.prev = rxd;
            q_d.cnt  = q_q.cnt + 1'b1;
            case (q_q.state)
                ST_IDLE: begin
                    q_d.cnt = CNT_W'(1);
                    if (q_q.prev && !rxd) q_d.state = ST_START;
                end
                ST_START: begin
                    if (q_q.cnt == SMP_C && vote) begin
                        q_d.state = ST_IDLE;
                    end else if (q_q.cnt == LAST_PH) begin
                        q_d.state = ST_DATA;
                        q_d.idx   = '0;
                    end
                end
                ST_DATA: begin
                    if (q_q.cnt == SMP_C)
                        q_d.sreg = {vote, q_q.sreg[DATA_BITS-1:1]};
                    if (q_q.cnt == LAST_PH) begin
                        if (q_q.idx == LAST_BIT) q_d.state = ST_STOP;
                        else                     q_d.idx   = q_q.idx + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q_q.cnt == SMP_C) begin
                        q_d.state = ST_IDLE;
                        xfer      = vote;
                    end
                end
                default: q_d.state = ST_IDLE;
            endcase
        end
    end

    assign active    = (q_q.state != ST_IDLE);
    assign phase     = q_q.cnt;
    assign xfer_data = q_q.sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q       <= '0;
            q_q.state <= ST_IDLE;
        end else begin
            q_q <= q_d;
        end
    end

    // R1: nothing in the bit timing moves without a sample pulse
    a_r1_quiet_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> ($stable(q_q.cnt) && $stable(q_q.state)));

    // R4: a transfer comes only from the stop state
    a_r4_xfer_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> (q_q.state == ST_IDLE));
endmodule

// File: rtl/orx_holdbuf.sv
module orx_holdbuf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer,
    input  logic [DATA_BITS-1:0] xfer_data,
    input  logic                 fifo_mode,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 fifo_push,
    output logic                 rx_irq,
    output logic                 overrun
);
    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 push;
        logic                 irq;
        logic                 ovr;
    } hb_t;

    hb_t q_q, q_d;

    always_comb begin
        q_d      = q_q;
        q_d.push = 1'b0;
        q_d.irq  = 1'b0;
        if (rd_strobe) begin
            q_d.full = 1'b0;
            q_d.ovr  = 1'b0;
        end
        if (xfer) begin
            q_d.data = xfer_data;
            if (fifo_mode) begin
                q_d.push = 1'b1;
                q_d.full = 1'b0;
            end else begin
                q_d.full = 1'b1;
                q_d.irq  = 1'b1;
                if (q_q.full && !rd_strobe) q_d.ovr = 1'b1;
            end
        end
    end

    assign rx_data   = q_q.data;
    assign rx_full   = q_q.full;
    assign fifo_push = q_q.push;
    assign rx_irq    = q_q.irq;
    assign overrun   = q_q.ovr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // R6: interrupt only while the buffer reports full
    a_r6_irq_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);

    // R7: a FIFO hand-off never leaves the full flag set
    a_r7_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !rx_full);

    // R9: overrun can only appear on a full buffer
    a_r9_overrun_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> rx_full);

    // R8: a read with no new character releases the buffer
    a_r8_read_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !xfer) |=> (!rx_full && !overrun));
endmodule

// File: rtl/orx_receiver.sv
module orx_receiver #(
    parameter int CNT_W     = 4,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 os_tick,
    input  logic                 fifo_mode,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_full,
    output logic                 fifo_push,
    output logic                 rx_irq,
    output logic                 overrun
);
    logic                 active;
    logic [CNT_W-1:0]     phase;
    logic                 vote;
    logic                 xfer;
    logic [DATA_BITS-1:0] xfer_data;

    orx_sampler #(.CNT_W(CNT_W)) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .os_tick (os_tick),
        .rxd     (rxd),
        .active  (active),
        .phase   (phase),
        .vote    (vote)
    );

    orx_framer #(.CNT_W(CNT_W), .DATA_BITS(DATA_BITS)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .vote      (vote),
        .active    (active),
        .phase     (phase),
        .xfer      (xfer),
        .xfer_data (xfer_data)
    );

    orx_holdbuf #(.DATA_BITS(DATA_BITS)) u_holdbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .xfer_data (xfer_data),
        .fifo_mode (fifo_mode),
        .rd_strobe (rd_strobe),
        .rx_data   (rx_data),
        .rx_full   (rx_full),
        .fifo_push (fifo_push),
        .rx_irq    (rx_irq),
        .overrun   (overrun)
    );

    // R1: a character can only complete on a sample pulse
    a_r1_xfer_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> os_tick);

    // R7: push and interrupt are mutually exclusive
    a_r7_push_xor_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_push, rx_irq}));
endmodule

// File: tb/orx_receiver_bench.sv
`timescale 1ns/1ps
module orx_receiver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, fifo_push, rx_irq, overrun;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int push_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    orx_receiver u_orx_receiver (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .fifo_mode(fifo_mode), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_full(rx_full), .fifo_push(fifo_push), .rx_irq(rx_irq), .overrun(overrun)
    );

    always @(negedge clk) begin
        if (rx_irq)    irq_cnt++;
        if (fifo_push) push_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic v, input int gap);
        @(negedge clk);
        rxd = v;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // flip bit k corrupts pulse 7+k of the bit
    task automatic send_bit(input logic v, input logic [2:0] flip, input int gap);
        for (int p = 1; p <= 16; p++) begin
            logic lv;
            lv = v;
            if (p >= 7 && p <= 9 && flip[p-7]) lv = ~v;
            tick(lv, gap);
        end
    endtask

    function automatic logic [2:0] flip_for(input int mode, input int i);
        if (mode == 1) return 3'b001 << (i % 3);
        if (mode == 2) return (i == 0 || i == 5) ? 3'b110 : 3'b000;
        return 3'b000;
    endfunction

    task automatic send_frame(input logic [7:0] d, input int mode, input logic stopv, input int gap);
        tick(1'b1, gap);
        tick(1'b1, gap);
        send_bit(1'b0, 3'b000, gap);
        for (int i = 0; i < 8; i++) send_bit(d[i], flip_for(mode, i), gap);
        send_bit(stopv, 3'b000, gap);
        tick(1'b1, gap);
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
        end
    end

    initial begin
        int i0, p0;
        repeat (5) @(negedge clk);
        // R10: reset values
        chk("R10 rx_data", rx_data, 0);
        chk("R10 rx_full", rx_full, 0);
        chk("R10 fifo_push", fifo_push, 0);
        chk("R10 rx_irq", rx_irq, 0);
        chk("R10 overrun", overrun, 0);
        rst_n = 1'b1;
        repeat (3) tick(1'b1, 0);

        // R1/R2/R4/R5/R6/R8: every byte, one corrupt sample per bit, uneven tick spacing
        for (int v = 0; v < 256; v++) begin
            i0 = irq_cnt;
            send_frame(v[7:0], 1, 1'b1, (v % 4 == 3) ? 2 : 0);
            chk("R5 rx_full set", rx_full, 1);
            chk("R2 R4 data", rx_data, v);
            chk("R6 one irq", irq_cnt, i0 + 1);
            do_read();
            chk("R8 full cleared", rx_full, 0);
        end

        // R1: wide constant spacing between sample pulses
        send_frame(8'h96, 0, 1'b1, 3);
        chk("R1 wide spacing", rx_data, 8'h96);
        do_read();

        // R2: two corrupt samples on bits 0 and 5 invert them
        send_frame(8'hA5, 2, 1'b1, 0);
        chk("R2 double flip", rx_data, 8'hA5 ^ 8'h21);
        do_read();

        // R3: short start pulses are rejected
        i0 = irq_cnt;
        repeat (4) tick(1'b0, 0);
        repeat (20) tick(1'b1, 0);
        repeat (7) tick(1'b0, 0);
        repeat (20) tick(1'b1, 0);
        chk("R3 glitch no full", rx_full, 0);
        chk("R3 glitch no irq", irq_cnt, i0);
        chk("R3 glitch data kept", rx_data, 8'hA5 ^ 8'h21);
        send_frame(8'h3C, 0, 1'b1, 0);
        chk("R3 next frame ok", rx_data, 8'h3C);
        do_read();

        // R4: a low stop bit discards the character
        i0 = irq_cnt;
        send_frame(8'h5A, 0, 1'b0, 0);
        repeat (4) tick(1'b1, 0);
        chk("R4 bad stop no full", rx_full, 0);
        chk("R4 bad stop no irq", irq_cnt, i0);
        chk("R4 bad stop data kept", rx_data, 8'h3C);
        send_frame(8'hC3, 0, 1'b1, 0);
        chk("R4 recovery", rx_data, 8'hC3);
        do_read();

        // R9: overwrite of an unread character
        send_frame(8'h11, 0, 1'b1, 0);
        chk("R9 no overrun yet", overrun, 0);
        send_frame(8'h22, 0, 1'b1, 0);
        chk("R9 overrun set", overrun, 1);
        chk("R9 data overwritten", rx_data, 8'h22);
        chk("R9 still full", rx_full, 1);
        do_read();
        chk("R8 overrun cleared", overrun, 0);
        chk("R8 full cleared", rx_full, 0);

        // R7: FIFO hand-off
        fifo_mode = 1'b1;
        i0 = irq_cnt;
        p0 = push_cnt;
        send_frame(8'h77, 0, 1'b1, 0);
        chk("R7 one push", push_cnt, p0 + 1);
        chk("R7 full clear", rx_full, 0);
        chk("R7 no irq", irq_cnt, i0);
        chk("R7 data", rx_data, 8'h77);
        send_frame(8'hE1, 1, 1'b1, 1);
        chk("R7 second push", push_cnt, p0 + 2);
        chk("R7 no overrun", overrun, 0);
        fifo_mode = 1'b0;

        done = 1'b1;
        summary();
    end
endmodule